// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst into a synchronous pipelined SRAM. When an address strobe is seen on a rising clock edge, it captures the full input address. The two low bits become the start of the burst. On later clocks where the advance input is high, the block steps through the remaining beats. The upper address bits stay as they were captured for the whole burst.

There are two active-low strobes: one from the processor side and one from the cache-controller side. If both are low in the same cycle, the processor strobe wins. A registered flag tells the array control which side opened the current burst. The order of the four beats is fixed when the burst is loaded, using the order-select input. Interleaved order takes the start XOR the beat count. Linear order takes the start plus the beat count, modulo four. In both orders the fifth position wraps back to the start.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, word_addr reads 0 and by_proc reads 0.
- R2: When proc_strobe_n or ctrl_strobe_n is 0 at a rising edge, word_addr equals the addr_in of that edge from the next cycle on.
- R3: When both strobes are 0 at the same edge, by_proc becomes 1. When only ctrl_strobe_n is 0, by_proc becomes 0.
- R4: A burst loaded with order_sel = 1 is interleaved. After k advances, word_addr[1:0] = start XOR (k mod 4).
- R5: A burst loaded with order_sel = 0 is linear. After k advances, word_addr[1:0] = (start + k) mod 4.
- R6: At an edge with both strobes at 1 and advance at 0, word_addr keeps its value.
- R7: After four advances without a load, word_addr[1:0] is back to the loaded start value.
- R8: word_addr[ADDR_W-1:2] changes only at an edge where a strobe is 0.
- R9: order_sel is sampled only at a load edge. Changing it during a burst does not change the sequence.
- R10: At an edge where a strobe is 0 and advance is 1, the load takes effect and the advance is discarded.

Each advance means one edge with advance at 1 and both strobes at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, has priority |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| advance | input | 1 | Step to the next beat when high |
| order_sel | input | 1 | 1 = interleaved, 0 = linear, taken at load |
| addr_in | input | ADDR_W | Address captured on a strobe |
| word_addr | output | ADDR_W | Current burst word address |
| by_proc | output | 1 | 1 if the current burst was loaded by the processor strobe |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge. They also assume that a burst starts only with a strobe after reset, so the wrap check is armed only once a load has been seen. The stimulus changes the inputs only on falling edges. It draws the strobes sparsely, so that runs of advances often cover the wrap. It toggles order_sel freely in mid-burst, which is legal because that input is ignored outside loads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PROC = 2'd1,
      SRC_CTRL = 2'd2
   } src_e;

   // Variants of the order network selected by ORDERS parameter
   localparam int ORDERS_BOTH       = 0;
   localparam int ORDERS_LINEAR     = 1;
   localparam int ORDERS_INTERLEAVE = 2;

endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
   import burst_seq_pkg::*;
(
   input  logic proc_strobe_n,
   input  logic ctrl_strobe_n,
   output logic load,
   output src_e src
);

   always_comb begin
      if (!proc_strobe_n) begin
         src = SRC_PROC;
      end else if (!ctrl_strobe_n) begin
         src = SRC_CTRL;
      end else begin
         src = SRC_NONE;
      end
   end

   assign load = (src != SRC_NONE);

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat <= '0;
      end else if (clear) begin
         beat <= '0;
      end else if (step) begin
         beat <= beat + ONE;
      end
   end

endmodule

// File: rtl/order_map.sv
module order_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2,
   parameter int ORDERS = ORDERS_BOTH
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] beat,
   input  order_e            order,
   output logic [BEAT_W-1:0] low
);

   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] ilv_low;

   assign lin_low = start + beat;
   assign ilv_low = start ^ beat;

   generate
      if (ORDERS == ORDERS_LINEAR) begin : g_lin
         assign low = lin_low;
      end else if (ORDERS == ORDERS_INTERLEAVE) begin : g_ilv
         assign low = ilv_low;
      end else begin : g_both
         assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int BEAT_W = 2,
   parameter int ORDERS = ORDERS_BOTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              proc_strobe_n,
   input  logic              ctrl_strobe_n,
   input  logic              advance,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] word_addr,
   output logic              by_proc
);

   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("burst_addr_seq: BEAT_W must be at least 1");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
      end
      if (ORDERS < ORDERS_BOTH || ORDERS > ORDERS_INTERLEAVE) begin : g_bad_ord
         $error("burst_addr_seq: ORDERS out of range");
      end
   endgenerate

   logic              load;
   src_e              src;
   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] start_q;
   order_e            order_q;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] low;

   strobe_arbiter u_arb (
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .load          (load),
      .src           (src)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         start_q <= '0;
         order_q <= ORD_LINEAR;
         by_proc <= 1'b0;
      end else if (load) begin
         hi_q    <= addr_in[ADDR_W-1:BEAT_W];
         start_q <= addr_in[BEAT_W-1:0];
         order_q <= order_e'(order_sel);
         by_proc <= (src == SRC_PROC);
      end
   end

   beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .step  (advance),
      .beat  (beat)
   );

   order_map #(.BEAT_W(BEAT_W), .ORDERS(ORDERS)) u_map (
      .start (start_q),
      .beat  (beat),
      .order (order_q),
      .low   (low)
   );

   assign word_addr = {hi_q, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 19,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              proc_strobe_n,
   input logic              ctrl_strobe_n,
   input logic              advance,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] word_addr,
   input logic              by_proc
);

   logic              ld;
   logic              ck_valid;
   logic [BEAT_W-1:0] ck_cnt;
   logic [ADDR_W-1:0] ck_base;

   assign ld = !proc_strobe_n || !ctrl_strobe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_valid <= 1'b0;
         ck_cnt   <= '0;
         ck_base  <= '0;
      end else if (ld) begin
         ck_valid <= 1'b1;
         ck_cnt   <= '0;
         ck_base  <= addr_in;
      end else if (advance) begin
         ck_cnt   <= ck_cnt + BEAT_W'(1);
      end
   end

   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (word_addr == '0 && !by_proc);
      end
   end

   // R2 and R7: at beat zero (after load or after a full wrap) address equals captured base
   assert_base_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ck_valid && ck_cnt == '0 |-> word_addr == ck_base);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> word_addr == $past(addr_in));

   assert_proc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_strobe_n |=> by_proc);

   assert_ctrl_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      proc_strobe_n && !ctrl_strobe_n |=> !by_proc);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld && !advance |=> $stable(word_addr) && $stable(by_proc));

   assert_step_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld && advance |=> word_addr != $past(word_addr));

   assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          proc_strobe_n = 1'b1;
   logic          ctrl_strobe_n = 1'b1;
   logic          advance = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] word_addr;
   logic          by_proc;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_beat = '0;
   logic          m_ilv = 1'b0;
   logic          m_proc = 1'b0;

   always #2 clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .advance       (advance),
      .order_sel     (order_sel),
      .addr_in       (addr_in),
      .word_addr     (word_addr),
      .by_proc       (by_proc)
   );

   function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k,
                                          input logic ilv);
      logic [2:0] sum;
      if (ilv) return s ^ k;
      sum = {1'b0, s} + {1'b0, k};
      return sum[1:0];
   endfunction

   task automatic check(input string tag);
      logic [AW-1:0] ea;
      ea = {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, m_ilv)};
      checks++;
      if (word_addr !== ea || by_proc !== m_proc) begin
         failures++;
         $display("FAIL %s: word_addr=%h by_proc=%b expected word_addr=%h by_proc=%b",
                  tag, word_addr, by_proc, ea, m_proc);
      end
   endtask

   // Called at a falling edge: drive, predict next rising edge, check at next falling edge
   task automatic step(input logic pn, input logic cn, input logic adv, input logic md,
                       input logic [AW-1:0] a, input string tag);
      proc_strobe_n = pn;
      ctrl_strobe_n = cn;
      advance = adv;
      order_sel = md;
      addr_in = a;
      if (!pn || !cn) begin
         m_base = a;
         m_beat = '0;
         m_ilv = md;
         m_proc = !pn;
      end else if (adv) begin
         m_beat = m_beat + 2'd1;
      end
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] hi;
      void'($urandom(32'h5A17));
      repeat (2) @(negedge clk);
      check("R1 reset");
      check("R1 reset hold");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // Interleaved burst from start 2: 2,3,0,1 then wrap to 2
      hi = AW'(19'h2A5C4);
      step(0, 1, 0, 1, hi | AW'(2), "R2 load proc");
      step(1, 1, 1, 1, '0, "R4 interleave beat1");
      step(1, 1, 1, 0, '0, "R4 interleave beat2 R9");
      step(1, 1, 1, 0, '0, "R4 interleave beat3");
      step(1, 1, 1, 1, '0, "R7 interleave wrap");
      step(1, 1, 0, 1, '0, "R6 hold");
      step(1, 1, 0, 0, '1, "R6 hold again R8");

      // Linear burst from start 3: 3,0,1,2 then wrap to 3
      step(1, 0, 0, 0, AW'(19'h01233), "R2 load ctrl R3");
      step(1, 1, 1, 1, '0, "R5 linear beat1 R9");
      step(1, 1, 1, 1, '0, "R5 linear beat2 R8");
      step(1, 1, 1, 0, '0, "R5 linear beat3");
      step(1, 1, 1, 0, '0, "R7 linear wrap");

      // Priority and load-versus-advance
      step(0, 0, 0, 1, AW'(19'h7FFF1), "R3 both strobes");
      step(1, 1, 1, 1, '0, "R4 after both");
      step(1, 0, 1, 0, AW'(19'h00002), "R10 load beats advance");
      step(0, 1, 1, 1, AW'(19'h40003), "R10 proc load with advance");
      step(1, 1, 1, 0, '0, "R4 start3 beat1");

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic pn, cn, adv, md;
         pn = ($urandom_range(0, 9) != 0);
         cn = ($urandom_range(0, 7) != 0);
         adv = ($urandom_range(0, 3) != 0);
         md = 1'($urandom_range(0, 1));
         step(pn, cn, adv, md, AW'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule